// File: doc/BRIEF.md
# Refresh Scheduler and Arbiter

This block sits in a memory controller between the host request path and the DRAM command path. An interval timer produces one owed refresh every `INTERVAL_CYC` clock cycles, and a counter keeps the number of refreshes owed but not yet issued. A fixed-priority arbiter then turns those owed refreshes into refresh commands. Refresh always wins over host reads and writes. Each command makes its target unavailable for `TRFC_CYC` cycles, and no host grant may reach a busy target.

Three policies are selectable. In distributed mode each owed refresh is issued as soon as it is owed, which spreads the host stalls evenly. In burst mode refreshes pile up until a full window's worth is owed, and then all of them are issued back to back in a single blackout. In per-bank mode each refresh goes to one bank, chosen round-robin, so host traffic to the other banks keeps flowing. The host side is a valid/ready handshake that carries a bank number. A request that is not granted stays pending and is never dropped. The timing parameters default to values derived from the clock period by package functions: 8192 refreshes per 64 ms window and a 260 ns refresh cycle time.

Top module: `refresh_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, `ref_valid_o` and `late_o` are 0 and `host_ready_o` is 1.
- R2: One refresh becomes owed every `INTERVAL_CYC` cycles. In distributed (`policy_i`=0) and per-bank (`policy_i`=2) modes, consecutive refresh commands are exactly `INTERVAL_CYC` cycles apart, which gives `REFS_PER_WINDOW` commands per window of `REFS_PER_WINDOW*INTERVAL_CYC` cycles.
- R3: No host grant (`host_valid_i && host_ready_o`) goes to a bank in the cycle it receives a refresh command, nor in the `TRFC_CYC-1` cycles after it.
- R4: A refresh is issued only when at least one is owed. When it is due in the same cycle as a host request, the refresh is issued and the request sees `host_ready_o`=0. Issuing a refresh never increases the owed count.
- R5: In distributed mode a refresh blocks every bank (`ref_all_o`=1), `host_ready_o` is 1 whenever the requested bank is not busy, and no host request waits more than `TRFC_CYC` cycles.
- R6: In burst mode (`policy_i`=1), no refresh is issued until `REFS_PER_WINDOW` are owed. Exactly `REFS_PER_WINDOW` refreshes are then issued `TRFC_CYC` cycles apart. Bursts start `REFS_PER_WINDOW*INTERVAL_CYC` cycles apart, and the host stays blocked throughout the blackout.
- R7: In per-bank mode a refresh blocks only bank `ref_bank_o` (`ref_all_o`=0). Requests to other banks are granted during its busy time, and no request waits more than `TRFC_CYC` cycles.
- R8: In per-bank mode the refreshed bank follows the order 0, 1, ..., `NUM_BANKS-1`, 0, ... starting from reset, so every bank receives an equal number of refreshes, within one.
- R9: `late_o` is 1 exactly when the owed count exceeds `MAX_POSTPONE`. The owed count rises by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| policy_i | input | 2 | 0 distributed, 1 burst, 2 per-bank (3 acts as distributed); held steady outside reset |
| host_valid_i | input | 1 | Host read/write request pending |
| host_bank_i | input | BANK_W | Bank addressed by the host request |
| host_ready_o | output | 1 | Request granted this cycle when valid |
| ref_valid_o | output | 1 | Refresh command issued this cycle |
| ref_all_o | output | 1 | Command refreshes all banks |
| ref_bank_o | output | BANK_W | Target bank of a per-bank refresh |
| late_o | output | 1 | Owed refreshes exceed the postponement limit |

## Verification
The collision of interest is a refresh becoming due in the same cycle as a pending host request. The host model keeps `host_valid_i` high almost all the time and holds every request until it is granted. As a result, each refresh issue lands on a waiting request in all three policies, and the request's bank sweeps through all banks. In every cycle the bench rebuilds the busy window of each bank from the observed refresh commands and compares `host_ready_o` against it: low on the colliding bank, and in per-bank mode still high for the other banks. The longest stall measured is then held against `TRFC_CYC` in distributed and per-bank modes, and against the full burst length in burst mode.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [1:0] {
    POL_DIST  = 2'd0,
    POL_BURST = 2'd1,
    POL_BANK  = 2'd2
  } rfs_policy_e;

  // nanoseconds to whole cycles, rounded down (spacing must not be exceeded)
  function automatic int cyc_floor(input int ns, input int clk_ps);
    return (ns * 1000) / clk_ps;
  endfunction

  // nanoseconds to whole cycles, rounded up (busy time must be covered)
  function automatic int cyc_ceil(input int ns, input int clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rfs_tick_gen.sv
module rfs_tick_gen #(
  parameter int PERIOD = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int W = rfs_pkg::idx_width(PERIOD);
  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == W'(PERIOD - 1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rfs_owed_ctr.sv
module rfs_owed_ctr #(
  parameter int W     = 8,
  parameter int LIMIT = 255
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] cnt_q;
  logic         at_top, at_zero;

  assign at_top  = (cnt_q == W'(LIMIT));
  assign at_zero = (cnt_q == '0);
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && !dec_i && !at_top)  cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i && !at_zero) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/rfs_bank_timer.sv
module rfs_bank_timer #(
  parameter int TRFC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int W = rfs_pkg::idx_width(TRFC + 1);
  logic [W-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (start_i) cnt_q <= W'(TRFC - 1);
    else if (busy_o)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/refresh_arbiter.sv
module refresh_arbiter #(
  parameter int NUM_BANKS       = 8,
  parameter int CLK_PS          = 2500,
  parameter int WINDOW_NS       = 64_000_000,
  parameter int REFS_PER_WINDOW = 8192,
  parameter int TRFC_NS         = 260,
  parameter int INTERVAL_CYC    = rfs_pkg::cyc_floor(WINDOW_NS / REFS_PER_WINDOW, CLK_PS),
  parameter int TRFC_CYC        = rfs_pkg::cyc_ceil(TRFC_NS, CLK_PS),
  parameter int MAX_POSTPONE    = REFS_PER_WINDOW,
  localparam int BANK_W         = rfs_pkg::idx_width(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        policy_i,
  input  logic              host_valid_i,
  input  logic [BANK_W-1:0] host_bank_i,
  output logic              host_ready_o,
  output logic              ref_valid_o,
  output logic              ref_all_o,
  output logic [BANK_W-1:0] ref_bank_o,
  output logic              late_o
);
  import rfs_pkg::*;

  localparam int OWED_LIMIT = REFS_PER_WINDOW + MAX_POSTPONE + 1;
  localparam int OWED_W     = idx_width(OWED_LIMIT + 1);
  localparam int LEFT_W     = idx_width(REFS_PER_WINDOW + 1);

  rfs_policy_e pol;
  assign pol = rfs_policy_e'(policy_i);

  // named internal events
  logic                 tick;          // one more refresh owed
  logic                 issue;         // refresh command this cycle
  logic [OWED_W-1:0]    owed_q;
  logic [NUM_BANKS-1:0] timer_busy;    // busy after the issue cycle
  logic [NUM_BANKS-1:0] ref_hit;       // bank targeted by this cycle's command
  logic [NUM_BANKS-1:0] bank_busy;
  logic                 any_timer_busy;
  logic                 draining_q;
  logic [LEFT_W-1:0]    left_q;
  logic [BANK_W-1:0]    rr_q;
  logic                 per_bank;
  logic                 burst_enter;

  rfs_tick_gen #(.PERIOD(INTERVAL_CYC)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  rfs_owed_ctr #(.W(OWED_W), .LIMIT(OWED_LIMIT)) u_owed (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(tick), .dec_i(issue), .count_o(owed_q)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign ref_hit[b]   = issue && (!per_bank || rr_q == BANK_W'(b));
    assign bank_busy[b] = ref_hit[b] || timer_busy[b];
    rfs_bank_timer #(.TRFC(TRFC_CYC)) u_tmr (
      .clk_i(clk_i), .rst_ni(rst_ni), .start_i(ref_hit[b]), .busy_o(timer_busy[b])
    );
  end

  assign any_timer_busy = |timer_busy;
  assign per_bank       = (pol == POL_BANK);
  assign burst_enter    = (pol == POL_BURST) && !draining_q &&
                          (owed_q >= OWED_W'(REFS_PER_WINDOW));

  always_comb begin
    unique case (pol)
      POL_BURST: issue = draining_q && (left_q != '0) && !any_timer_busy;
      default:   issue = (owed_q != '0) && !any_timer_busy;
    endcase
  end

  // burst blackout sequencing
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      draining_q <= 1'b0;
      left_q     <= '0;
    end else if (burst_enter) begin
      draining_q <= 1'b1;
      left_q     <= LEFT_W'(REFS_PER_WINDOW);
    end else if (draining_q) begin
      if (issue) left_q <= left_q - 1'b1;
      else if (left_q == '0 && !any_timer_busy) draining_q <= 1'b0;
    end
  end

  // round-robin bank pointer for per-bank refresh
  always_ff @(posedge clk_i) begin
    if (!rst_ni) rr_q <= '0;
    else if (issue && per_bank)
      rr_q <= (rr_q == BANK_W'(NUM_BANKS - 1)) ? '0 : rr_q + 1'b1;
  end

  assign ref_valid_o  = issue;
  assign ref_all_o    = !per_bank;
  assign ref_bank_o   = rr_q;
  assign late_o       = (owed_q > OWED_W'(MAX_POSTPONE));
  assign host_ready_o = !bank_busy[host_bank_i] && !((pol == POL_BURST) && draining_q);

endmodule

// File: rtl/refresh_arbiter_chk.sv
module refresh_arbiter_chk #(
  parameter int NUM_BANKS    = 8,
  parameter int BANK_W       = 3,
  parameter int OWED_W       = 8,
  parameter int TRFC_CYC     = 4,
  parameter int MAX_POSTPONE = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_valid,
  input logic [BANK_W-1:0] host_bank,
  input logic              host_ready,
  input logic              ref_valid,
  input logic              ref_all,
  input logic [BANK_W-1:0] ref_bank,
  input logic              late,
  input logic [OWED_W-1:0] owed
);
  localparam int SW = (TRFC_CYC > 1) ? $clog2(TRFC_CYC + 1) : 1;

  logic [SW-1:0]        since_q [NUM_BANKS];
  logic [NUM_BANKS-1:0] hit, recent;
  logic [BANK_W-1:0]    rr_m;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_m
    assign hit[b]    = ref_valid && (ref_all || ref_bank == BANK_W'(b));
    assign recent[b] = (since_q[b] != '0);
    always_ff @(posedge clk) begin
      if (!rst_n)      since_q[b] <= '0;
      else if (hit[b]) since_q[b] <= SW'(TRFC_CYC - 1);
      else if (recent[b]) since_q[b] <= since_q[b] - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rr_m <= '0;
    else if (ref_valid && !ref_all)
      rr_m <= (rr_m == BANK_W'(NUM_BANKS - 1)) ? '0 : rr_m + 1'b1;
  end

  a_r3_no_grant_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready) |-> (!recent[host_bank] && !hit[host_bank]));

  a_r4_only_when_owed: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |-> (owed != '0));

  a_r4_issue_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> (owed <= $past(owed)));

  a_r6_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |-> (recent == '0));

  a_r8_rr_order: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && !ref_all) |-> (ref_bank == rr_m));

  a_r9_late_step: assert property (@(posedge clk) disable iff (!rst_n)
    !late |=> (owed <= OWED_W'(MAX_POSTPONE + 1)));

endmodule

bind refresh_arbiter refresh_arbiter_chk #(
  .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .OWED_W(OWED_W),
  .TRFC_CYC(TRFC_CYC), .MAX_POSTPONE(MAX_POSTPONE)
) u_chk (
  .clk(clk_i), .rst_n(rst_ni), .host_valid(host_valid_i), .host_bank(host_bank_i),
  .host_ready(host_ready_o), .ref_valid(ref_valid_o), .ref_all(ref_all_o),
  .ref_bank(ref_bank_o), .late(late_o), .owed(owed_q)
);

// File: tb/refresh_arbiter_tb_top.sv
`timescale 1ns/1ps
module refresh_arbiter_tb_top;
  localparam int NB   = 4;
  localparam int INTV = 40;
  localparam int TRFC = 6;
  localparam int REFS = 8;
  localparam int WIN  = REFS * INTV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] policy = 2'd0;
  logic       host_valid = 1'b0;
  logic [1:0] host_bank = '0;
  logic       host_ready, ref_valid, ref_all, late;
  logic [1:0] ref_bank;
  logic       l_ready, l_valid, l_all, l_late;
  logic [1:0] l_bank;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  refresh_arbiter #(.NUM_BANKS(NB), .REFS_PER_WINDOW(REFS), .INTERVAL_CYC(INTV),
                    .TRFC_CYC(TRFC), .MAX_POSTPONE(REFS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(policy), .host_valid_i(host_valid),
    .host_bank_i(host_bank), .host_ready_o(host_ready), .ref_valid_o(ref_valid),
    .ref_all_o(ref_all), .ref_bank_o(ref_bank), .late_o(late));

  // burst instance with a tight postponement limit, for the late flag
  refresh_arbiter #(.NUM_BANKS(NB), .REFS_PER_WINDOW(REFS), .INTERVAL_CYC(INTV),
                    .TRFC_CYC(TRFC), .MAX_POSTPONE(4)) late_i (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(2'd1), .host_valid_i(1'b0),
    .host_bank_i(2'd0), .host_ready_o(l_ready), .ref_valid_o(l_valid),
    .ref_all_o(l_all), .ref_bank_o(l_bank), .late_o(l_late));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_mode(input logic [1:0] pol, input int cycles);
    int rem [NB];
    int bank_cnt [NB];
    bit busy [NB];
    int last_ref = -1, burst_start = -1, burst_cnt = 0;
    int stall = 0, max_stall = 0, rr_exp = 0, first_late = -1;
    bit granted, any_busy;
    policy = pol; host_valid = 1'b0; host_bank = '0; rst_n = 1'b0;
    for (int b = 0; b < NB; b++) begin rem[b] = 0; bank_cnt[b] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ref_valid == 1'b0 && late == 1'b0 && l_late == 1'b0, "R1 reset quiet", ref_valid, 0);
    check(host_ready == 1'b1, "R1 ready in reset", host_ready, 1);
    rst_n = 1'b1; host_valid = 1'b1;
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      if (n == 0) check(host_ready == 1'b1 && ref_valid == 1'b0, "R1 after reset", host_ready, 1);
      any_busy = 1'b0;
      for (int b = 0; b < NB; b++) begin
        busy[b] = (ref_valid && (ref_all || ref_bank == 2'(b))) || rem[b] > 0;
        any_busy |= busy[b];
      end
      granted = host_valid && host_ready;
      if (granted) check(!busy[host_bank], "R3 grant in busy window", host_bank, -1);
      if (pol != 2'd1)
        check(host_ready == !busy[host_bank], pol == 2'd2 ? "R7 ready per bank" : "R5 ready",
              host_ready, !busy[host_bank]);
      else if (any_busy)
        check(!host_ready, "R6 blackout", host_ready, 0);
      if (host_valid && !host_ready) stall++;
      else begin if (stall > max_stall) max_stall = stall; stall = 0; end
      if (ref_valid) begin
        check(ref_all == (pol != 2'd2), "R7 ref_all", ref_all, pol != 2'd2);
        if (pol == 2'd1) begin
          if (last_ref >= 0 && n - last_ref == TRFC) burst_cnt++;
          else begin
            if (burst_start >= 0) begin
              check(burst_cnt == REFS, "R6 burst size", burst_cnt, REFS);
              check(n - burst_start == WIN, "R6 burst spacing", n - burst_start, WIN);
            end else
              check(n >= (REFS - 1) * INTV, "R6 early burst", n, (REFS - 1) * INTV);
            burst_start = n; burst_cnt = 1;
          end
        end else begin
          if (last_ref >= 0) check(n - last_ref == INTV, "R2 spacing", n - last_ref, INTV);
          if (pol == 2'd2) begin
            check(int'(ref_bank) == rr_exp, "R8 order", ref_bank, rr_exp);
            bank_cnt[ref_bank]++;
            rr_exp = (rr_exp + 1) % NB;
          end
        end
        last_ref = n;
      end
      for (int b = 0; b < NB; b++)
        if (ref_valid && (ref_all || ref_bank == 2'(b))) rem[b] = TRFC - 1;
        else if (rem[b] > 0) rem[b]--;
      check(late == 1'b0, "R9 late low", late, 0);
      if (l_late && first_late < 0) first_late = n;
      if (granted) begin
        host_bank = 2'((int'(host_bank) + 1 + n % 3) % NB);
        host_valid = (n % 5 != 0);
      end else if (!host_valid) host_valid = 1'b1;
    end
    if (pol == 2'd0) check(max_stall <= TRFC && max_stall > 0, "R5 worst stall", max_stall, TRFC);
    if (pol == 2'd2) check(max_stall <= TRFC, "R7 worst stall", max_stall, TRFC);
    if (pol == 2'd1) check(max_stall >= REFS * TRFC, "R6 blackout stall", max_stall, REFS * TRFC);
    if (pol != 2'd1) check(last_ref >= cycles - INTV, "R2 refresh count", last_ref, cycles - INTV);
    if (pol == 2'd2)
      for (int b = 1; b < NB; b++)
        check(bank_cnt[b] - bank_cnt[0] <= 1 && bank_cnt[0] - bank_cnt[b] <= 1 && bank_cnt[b] > 0,
              "R8 equal counts", bank_cnt[b], bank_cnt[0]);
    check(first_late >= 4 * INTV, "R9 late onset", first_late, 5 * INTV);
  endtask

  initial begin
    run_mode(2'd0, 5 * WIN);
    run_mode(2'd1, 5 * WIN);
    run_mode(2'd2, 5 * WIN);
    run_mode(2'd3, 2 * WIN);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule